// File: doc/BRIEF.md
# Coherent Line Presence Filter

This block keeps a small direct-mapped table of cache-line addresses. For each line it records which of a set of coherent masters may hold a copy. Every coherent request that arrives looks up its line, turns the recorded holders into a snoop target mask, and updates the holders from the request's opcode. Snoops can then go only to masters that may own the line, rather than to every master.

Each table slot holds a tag and a presence vector. A slot whose vector is all zero counts as empty, so there is no separate valid bit. A request can miss against an occupied slot and still need to install its own line. In that case the block first emits a back-invalidate mask naming the holders of the line it displaces, then installs the new tag.

Outputs are registered. They appear one clock after the request is sampled and stay high for one cycle only.

Top module: `snoop_presence_filter`

## Requirements
- R1: After reset every output is low and the table is empty. The first request to any line therefore produces no snoop and no back-invalidate.
- R2: One cycle after a request, `snp_mask` equals the line's recorded holders with the requester's bit cleared, for opcodes that snoop. `snp_valid` is high only when that mask is non-zero. Both outputs are low in any cycle that follows no request.
- R3: Shared reads (ReadShared 1, ReadClean 2, ReadNotSharedDirty 3) snoop the other holders and add the requester as a holder.
- R4: ReadOnce (0) snoops the other holders and leaves the presence vector unchanged.
- R5: The ownership opcodes (ReadUnique 4, CleanUnique 5, MakeUnique 6) snoop the other holders and leave only the requester recorded. WriteUnique (7) snoops the other holders, clears them, and keeps the requester's bit as it was.
- R6: WriteBack (8) and Evict (10) clear the requester's bit and send no snoop. WriteClean (9) sends no snoop and leaves the requester recorded.
- R7: CleanInvalid (12) and MakeInvalid (13) snoop the other holders and clear every bit. CleanShared (11) snoops the other holders and leaves the vector unchanged.
- R8: An opcode can leave a non-empty vector on a line that misses against an occupied slot. When it does, the next cycle shows `binv_valid` high and `binv_mask` equal to the displaced line's holders. The new line is installed with only the bits the opcode sets, and its snoop mask is zero.
- R9: An opcode that misses and would leave an empty vector does not change the resident entry and raises no back-invalidate.
- R10: Opcodes 14 and 15 have no effect on the table or the outputs.
- R11: An entry whose vector becomes all zero is freed. A later line mapping to that slot installs without a back-invalidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A coherent request is present this cycle |
| req_op | input | 4 | Request opcode (encodings in R3 to R10) |
| req_addr | input | ADDR_W (8) | Line address; the low bits index the table and the rest is the tag |
| req_id | input | ID_W (2) | Requesting master |
| snp_valid | output | 1 | Snoop mask is non-zero and valid |
| snp_mask | output | N_MASTERS (4) | Masters to snoop, one bit per master |
| binv_valid | output | 1 | A displaced entry must be back-invalidated |
| binv_mask | output | N_MASTERS (4) | Holders of the displaced line |

## Verification
The assertions check the output-timing rules on every cycle. A snoop is never raised without a request in the previous cycle. A raised snoop mask is never empty and never names the requester. A back-invalidate always traces to a request in the previous cycle.

Whether each opcode moves the presence bits correctly only shows up in later snoop masks. The same holds for whether misses keep or displace the resident line and whether freed slots reinstall cleanly. The bench's directed sequences cover these, together with a random mix of opcodes over a few conflicting addresses, checked against a model of the table.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic [3:0] {
    OP_RD_ONCE      = 4'd0,
    OP_RD_SHARED    = 4'd1,
    OP_RD_CLEAN     = 4'd2,
    OP_RD_NSD       = 4'd3,
    OP_RD_UNIQUE    = 4'd4,
    OP_CLEAN_UNIQUE = 4'd5,
    OP_MAKE_UNIQUE  = 4'd6,
    OP_WR_UNIQUE    = 4'd7,
    OP_WR_BACK      = 4'd8,
    OP_WR_CLEAN     = 4'd9,
    OP_EVICT        = 4'd10,
    OP_CLEAN_SHARED = 4'd11,
    OP_CLEAN_INVAL  = 4'd12,
    OP_MAKE_INVAL   = 4'd13
  } op_e;

  // Presence-vector action derived from an opcode
  typedef struct packed {
    logic snoop;        // snoop the other holders
    logic drop_others;  // clear every holder except the requester
    logic add_req;      // record the requester
    logic drop_req;     // remove the requester
  } act_t;

endpackage

// File: rtl/spf_op_decode.sv
module spf_op_decode
  import spf_pkg::*;
(
  input  logic [3:0] op,
  output act_t       act
);

  always_comb begin
    act = '0;
    case (op)
      OP_RD_ONCE, OP_CLEAN_SHARED:
        act.snoop = 1'b1;
      OP_RD_SHARED, OP_RD_CLEAN, OP_RD_NSD: begin
        act.snoop   = 1'b1;
        act.add_req = 1'b1;
      end
      OP_RD_UNIQUE, OP_CLEAN_UNIQUE, OP_MAKE_UNIQUE: begin
        act.snoop       = 1'b1;
        act.drop_others = 1'b1;
        act.add_req     = 1'b1;
      end
      OP_WR_UNIQUE: begin
        act.snoop       = 1'b1;
        act.drop_others = 1'b1;
      end
      OP_WR_BACK, OP_EVICT:
        act.drop_req = 1'b1;
      OP_CLEAN_INVAL, OP_MAKE_INVAL: begin
        act.snoop       = 1'b1;
        act.drop_others = 1'b1;
        act.drop_req    = 1'b1;
      end
      default: act = '0;  // WriteClean and unused codes
    endcase
  end

endmodule

// File: rtl/spf_vec_update.sv
module spf_vec_update
  import spf_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  act_t                 act,
  input  logic [N_MASTERS-1:0] cur_vec,
  input  logic [N_MASTERS-1:0] req_bit,
  output logic [N_MASTERS-1:0] snoop_vec,
  output logic [N_MASTERS-1:0] next_vec
);

  logic [N_MASTERS-1:0] others;
  logic [N_MASTERS-1:0] self_bit;

  always_comb begin
    others = cur_vec & ~req_bit;
    if (act.add_req)       self_bit = req_bit;
    else if (act.drop_req) self_bit = '0;
    else                   self_bit = cur_vec & req_bit;
    next_vec  = (act.drop_others ? '0 : others) | self_bit;
    snoop_vec = act.snoop ? others : '0;
  end

endmodule

// File: rtl/spf_table.sv
module spf_table #(
  parameter int N_SETS    = 8,
  parameter int TAG_W     = 5,
  parameter int N_MASTERS = 4,
  localparam int IDX_W    = $clog2(N_SETS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [TAG_W-1:0]     rd_tag,
  output logic [N_MASTERS-1:0] rd_vec,
  input  logic                 we,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [N_MASTERS-1:0] wr_vec
);

  logic [TAG_W-1:0]     tag_arr [N_SETS];
  logic [N_MASTERS-1:0] vec_arr [N_SETS];

  for (genvar g = 0; g < N_SETS; g++) begin : g_slot
    logic [TAG_W-1:0]     tag_q;
    logic [N_MASTERS-1:0] vec_q;
    logic                 slot_en;

    assign slot_en = we && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= '0;
        vec_q <= '0;
      end else if (slot_en) begin
        tag_q <= wr_tag;
        vec_q <= wr_vec;
      end
    end

    assign tag_arr[g] = tag_q;
    assign vec_arr[g] = vec_q;
  end

  assign rd_tag = tag_arr[rd_idx];
  assign rd_vec = vec_arr[rd_idx];

endmodule

// File: rtl/snoop_presence_filter.sv
module snoop_presence_filter
  import spf_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int N_SETS    = 8,
  parameter int ADDR_W    = 8,
  localparam int ID_W     = $clog2(N_MASTERS),
  localparam int IDX_W    = $clog2(N_SETS),
  localparam int TAG_W    = ADDR_W - IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [3:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [ID_W-1:0]      req_id,
  output logic                 snp_valid,
  output logic [N_MASTERS-1:0] snp_mask,
  output logic                 binv_valid,
  output logic [N_MASTERS-1:0] binv_mask
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  // Lookup
  logic [IDX_W-1:0]     idx;
  logic [TAG_W-1:0]     tag;
  logic [TAG_W-1:0]     rd_tag;
  logic [N_MASTERS-1:0] rd_vec;
  logic [N_MASTERS-1:0] req_bit;
  logic [N_MASTERS-1:0] cur_vec;
  logic [N_MASTERS-1:0] snoop_vec;
  logic [N_MASTERS-1:0] next_vec;
  logic                 occupied;
  logic                 hit;
  logic                 displace;
  logic                 tbl_we;
  act_t                 act;

  assign idx = req_addr[IDX_W-1:0];
  assign tag = req_addr[ADDR_W-1:IDX_W];

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_req_bit
    assign req_bit[g] = (req_id == ID_W'(g));
  end

  spf_table #(
    .N_SETS   (N_SETS),
    .TAG_W    (TAG_W),
    .N_MASTERS(N_MASTERS)
  ) u_table (
    .clk   (clk),
    .rst_n (rst_ok),
    .rd_idx(idx),
    .rd_tag(rd_tag),
    .rd_vec(rd_vec),
    .we    (tbl_we),
    .wr_idx(idx),
    .wr_tag(tag),
    .wr_vec(next_vec)
  );

  spf_op_decode u_dec (
    .op (req_op),
    .act(act)
  );

  assign occupied = |rd_vec;
  assign hit      = occupied && (rd_tag == tag);
  assign cur_vec  = hit ? rd_vec : '0;

  spf_vec_update #(.N_MASTERS(N_MASTERS)) u_upd (
    .act      (act),
    .cur_vec  (cur_vec),
    .req_bit  (req_bit),
    .snoop_vec(snoop_vec),
    .next_vec (next_vec)
  );

  // Write on a hit (possibly freeing) or on an allocating miss
  assign displace = req_valid && occupied && !hit && (|next_vec);
  assign tbl_we   = req_valid && (hit || (|next_vec));

  // Output next-state
  logic                 snp_valid_d;
  logic [N_MASTERS-1:0] snp_mask_d;
  logic                 binv_valid_d;
  logic [N_MASTERS-1:0] binv_mask_d;

  always_comb begin
    snp_mask_d   = req_valid ? snoop_vec : '0;
    snp_valid_d  = |snp_mask_d;
    binv_valid_d = displace;
    binv_mask_d  = displace ? rd_vec : '0;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      snp_valid  <= 1'b0;
      snp_mask   <= '0;
      binv_valid <= 1'b0;
      binv_mask  <= '0;
    end else begin
      snp_valid  <= snp_valid_d;
      snp_mask   <= snp_mask_d;
      binv_valid <= binv_valid_d;
      binv_mask  <= binv_mask_d;
    end
  end

  // R2: a raised snoop always names at least one master
  p_snoop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    snp_valid |-> (|snp_mask));

  // R2: the requester is never a snoop target
  p_not_self_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    snp_valid |-> (snp_mask[$past(req_id)] == 1'b0));

  // R2: no request means quiet outputs in the next cycle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    !req_valid |=> (!snp_valid && !binv_valid));

  // R8: back-invalidate only follows a request and carries holders
  p_binv_cause_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    binv_valid |-> ($past(req_valid) && (|binv_mask)));

endmodule

// File: tb/snoop_presence_filter_bench.sv
`timescale 1ns/1ps
module snoop_presence_filter_bench;

  localparam int NM = 4;
  localparam int NS = 8;
  localparam int AW = 8;
  localparam int IW = 3;
  localparam int TW = AW - IW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [3:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_id;
  logic          snp_valid;
  logic [NM-1:0] snp_mask;
  logic          binv_valid;
  logic [NM-1:0] binv_mask;

  always #2.5 clk = ~clk;  // 200 MHz

  snoop_presence_filter #(.N_MASTERS(NM), .N_SETS(NS), .ADDR_W(AW))
  u_snoop_presence_filter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_id(req_id), .snp_valid(snp_valid),
    .snp_mask(snp_mask), .binv_valid(binv_valid), .binv_mask(binv_mask)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [TW-1:0] m_tag [NS];
  logic [NM-1:0] m_vec [NS];

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Expected per-opcode effect, written from the requirements
  function automatic void model_op(input logic [3:0] op, input logic [NM-1:0] cur,
                                   input logic [NM-1:0] rb,
                                   output logic [NM-1:0] sn, output logic [NM-1:0] nx);
    logic [NM-1:0] oth;
    oth = cur & ~rb;
    case (op)
      4'd0, 4'd11:       begin sn = oth; nx = cur;      end  // R4, R7
      4'd1, 4'd2, 4'd3:  begin sn = oth; nx = cur | rb; end  // R3
      4'd4, 4'd5, 4'd6:  begin sn = oth; nx = rb;       end  // R5
      4'd7:              begin sn = oth; nx = cur & rb; end  // R5
      4'd8, 4'd10:       begin sn = '0;  nx = cur & ~rb; end // R6
      4'd9:              begin sn = '0;  nx = cur;      end  // R6
      4'd12, 4'd13:      begin sn = oth; nx = '0;       end  // R7
      default:           begin sn = '0;  nx = cur;      end  // R10
    endcase
  endfunction

  task automatic issue(input logic [3:0] op, input logic [AW-1:0] addr,
                       input logic [1:0] id, input string rq);
    logic [IW-1:0] i;
    logic [TW-1:0] t;
    logic [NM-1:0] rb, cur, sn, nx, eb;
    logic occ, hit, disp;
    i = addr[IW-1:0];
    t = addr[AW-1:IW];
    rb = '0; rb[id] = 1'b1;
    occ = |m_vec[i];
    hit = occ && (m_tag[i] == t);
    cur = hit ? m_vec[i] : '0;
    model_op(op, cur, rb, sn, nx);
    disp = occ && !hit && (|nx);
    eb = disp ? m_vec[i] : '0;
    if (hit || (|nx)) begin
      m_tag[i] = t;
      m_vec[i] = nx;
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_id = id;
    @(negedge clk);
    req_valid = 1'b0;
    check(rq, "snp_mask",   32'(snp_mask),   32'(sn));
    check(rq, "snp_valid",  32'(snp_valid),  32'(|sn));
    check(rq, "binv_valid", 32'(binv_valid), 32'(disp));
    check(rq, "binv_mask",  32'(binv_mask),  32'(eb));
  endtask

  localparam logic [AW-1:0] LA = {5'd2, 3'd1};
  localparam logic [AW-1:0] LB = {5'd7, 3'd1};
  localparam logic [AW-1:0] LC = {5'd3, 3'd4};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NS; k++) begin m_tag[k] = '0; m_vec[k] = '0; end
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_id = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "snp_valid after reset", 32'(snp_valid), 32'd0);
    check("R1", "binv_valid after reset", 32'(binv_valid), 32'd0);
    issue(4'd1, LA, 2'd0, "R1");
    // R3 shared reads accumulate holders
    issue(4'd1, LA, 2'd1, "R3");
    issue(4'd2, LA, 2'd2, "R3");
    issue(4'd3, LA, 2'd3, "R3");
    // R4 ReadOnce leaves vector alone
    issue(4'd0, LA, 2'd0, "R4");
    issue(4'd0, LA, 2'd0, "R4");
    // R6 write-back group
    issue(4'd9, LA, 2'd1, "R6");
    issue(4'd0, LA, 2'd0, "R6");
    issue(4'd8, LA, 2'd1, "R6");
    issue(4'd10, LA, 2'd2, "R6");
    issue(4'd0, LA, 2'd0, "R6");
    // R5 ownership, R7 CleanShared, R5 WriteUnique, R11 freeing
    issue(4'd4, LA, 2'd2, "R5");
    issue(4'd11, LA, 2'd0, "R7");
    issue(4'd7, LA, 2'd0, "R5");
    issue(4'd0, LA, 2'd0, "R11");
    // R8 displacement
    issue(4'd1, LA, 2'd1, "R8");
    issue(4'd1, LB, 2'd3, "R8");
    issue(4'd0, LB, 2'd0, "R8");
    issue(4'd0, LA, 2'd0, "R8");
    // R9 non-allocating miss keeps resident line
    issue(4'd8, LA, 2'd1, "R9");
    issue(4'd12, LA, 2'd1, "R9");
    issue(4'd0, LB, 2'd0, "R9");
    // R10 unused codes
    issue(4'd14, LB, 2'd1, "R10");
    issue(4'd15, LB, 2'd3, "R10");
    issue(4'd0, LB, 2'd0, "R10");
    // R7 invalidating maintenance
    issue(4'd12, LB, 2'd0, "R7");
    issue(4'd0, LB, 2'd0, "R7");
    issue(4'd1, LC, 2'd1, "R7");
    issue(4'd1, LC, 2'd2, "R7");
    issue(4'd13, LC, 2'd1, "R7");
    issue(4'd0, LC, 2'd3, "R7");
    // R11 freed slot reinstalls without back-invalidate
    issue(4'd6, LA, 2'd2, "R11");
    issue(4'd5, LA, 2'd3, "R5");
    // Random mix over a few conflicting lines
    void'($urandom(32'd20240613));
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      a = {5'($urandom_range(0, 2)), 3'($urandom_range(0, 1))};
      issue(4'($urandom_range(0, 15)), a, 2'($urandom_range(0, 3)), "R2");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule